// File: doc/BRIEF.md
# Truncated Signed Power-of-Two Shift-Add Multiplier

This block multiplies a sign-magnitude data word by a coefficient that is written as a short sum of signed powers of two. Each coefficient term is a right shift of the data magnitude plus an add or a subtract. The block does the terms one at a time through a single shifter and a single accumulator, so one multiply costs a handful of cycles and very little adder area. That fits filters with a low sample rate and a tight power budget.

Bits that fall off the bottom of a shifted partial product are thrown away, so the product always fits a 16-bit window. A sticky flag records whether any nonzero bit was discarded. If one was, the result magnitude is raised by one LSB, which offsets the downward bias of the truncation. The caller gives a one-cycle start with both operands. It then waits for a one-cycle done, when a 16-bit two's-complement product appears and stays there until the next done.

Top module: `smul_top`

## Requirements
- R1: While reset is high, and directly after it, `done_o` is 0 and `prod_o` is 0.
- R2: Suppose a start is accepted at a clock edge while the block is idle, and the coefficient has k valid terms (k from 0 to 3). Then `done_o` is high for exactly one cycle, after the (k+1)-th following edge. Invalid terms cost no cycle.
- R3: A start seen while a multiply is in progress is ignored. It changes neither the result nor the timing of the running operation.
- R4: `data_i` bit 15 is the sign and bits 14:0 are the magnitude M. Term j sits at `coef_i[6j+5:6j]`: bit 5 is valid, bit 4 is subtract, and bits 3:0 are the right-shift amount s. The signed accumulator adds or subtracts floor(M / 2^s) for each valid term, starting with term 0 and going upwards.
- R5: A discarded nonzero bit in any valid term sets a sticky flag. With the flag set and a nonzero accumulated magnitude, the final magnitude is increased by 1. Otherwise no correction is made.
- R6: After every term the accumulator is clamped to the range -32767..+32767. The corrected final magnitude is also capped at 32767, so `prod_o` never equals 16'h8000 and never wraps.
- R7: The result is negative exactly when the data sign XOR the accumulator sign is 1, and the magnitude is nonzero. `prod_o` is the two's-complement form of that signed value.
- R8: If there are no valid terms, or the data magnitude is zero, or the accumulator ends at zero, `prod_o` is 0. This holds whatever the data sign.
- R9: `prod_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a multiply with the operands on this cycle |
| data_i | input | 16 | Data, sign-magnitude |
| coef_i | input | 18 | Three coefficient terms, 6 bits each |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| prod_o | output | 16 | Signed product, two's complement, held between pulses |

## Verification
Wrong internal state is visible at the ports only when the next done pulse arrives. A pending-term mask that is cleared wrongly moves that pulse earlier or later by one or more cycles. An accumulator or sticky error shows as a wrong product value in that pulse and in no earlier cycle. A sign error shows as a mirrored value, or as a forbidden 16'h8000. A reference model advances the expected done cycle and product on every edge. Both are compared every cycle, so a fault appears within at most four cycles of the start that exposes it.

// File: rtl/smul_pkg.sv
package smul_pkg;
    localparam int MAG_W   = 15;
    localparam int PROD_W  = MAG_W + 1;
    localparam int SHIFT_W = 4;
    localparam int TERMS   = 3;
    localparam int TERM_W  = SHIFT_W + 2;
    localparam int COEF_W  = TERMS * TERM_W;
    localparam int ACC_W   = MAG_W + 2;
    localparam int IDX_W   = (TERMS > 1) ? $clog2(TERMS) : 1;

    localparam logic [ACC_W-1:0] ACC_MAX = {2'b00, {MAG_W{1'b1}}};
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic               valid;
        logic               sub;
        logic [SHIFT_W-1:0] shamt;
    } term_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } smag_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    // Bits lost by a right shift of s
    function automatic logic [MAG_W-1:0] lost_mask(input logic [SHIFT_W-1:0] s);
        return ~({MAG_W{1'b1}} << s);
    endfunction

    function automatic logic signed [ACC_W-1:0] clamp_acc(input logic signed [ACC_W-1:0] v);
        if (v > $signed(ACC_MAX))
            return $signed(ACC_MAX);
        if (v < -$signed(ACC_MAX))
            return -$signed(ACC_MAX);
        return v;
    endfunction
endpackage

// File: rtl/smul_pick.sv
module smul_pick import smul_pkg::*; (
    input  logic [TERMS-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [TERMS-1:0] onehot
);
    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = TERMS - 1; i >= 0; i--) begin
            if (pend[i])
                idx = IDX_W'(i);
        end
        onehot = any ? (TERMS'(1) << idx) : '0;
    end
endmodule

// File: rtl/smul_shift.sv
module smul_shift import smul_pkg::*; (
    input  logic [MAG_W-1:0]   mag,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [MAG_W-1:0]   part,
    output logic               lost
);
    assign part = mag >> shamt;
    assign lost = |(mag & lost_mask(shamt));
endmodule

// File: rtl/smul_acc.sv
module smul_acc import smul_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    sub,
    input  logic [MAG_W-1:0]        part,
    input  logic                    lost,
    output logic signed [ACC_W-1:0] acc_q,
    output logic                    sticky_q
);
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] sum;

    assign ext = $signed({2'b00, part});
    assign sum = sub ? (acc_q - ext) : (acc_q + ext);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
        end else if (en) begin
            acc_q    <= clamp_acc(sum);
            sticky_q <= sticky_q | lost;
        end
    end
endmodule

// File: rtl/smul_final.sv
module smul_final import smul_pkg::*; (
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    sticky,
    input  logic                    dneg,
    output logic [PROD_W-1:0]       prod
);
    logic [ACC_W-1:0] mag_abs;
    logic [ACC_W-1:0] mag_fix;
    logic             neg;

    always_comb begin
        mag_abs = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);
        mag_fix = mag_abs;
        if (sticky && (mag_abs != '0))
            mag_fix = mag_abs + ACC_ONE;
        if (mag_fix > ACC_MAX)
            mag_fix = ACC_MAX;
        neg = dneg ^ acc[ACC_W-1];
        if (mag_fix == '0)
            prod = '0;
        else if (neg)
            prod = -mag_fix[PROD_W-1:0];
        else
            prod = mag_fix[PROD_W-1:0];
    end
endmodule

// File: rtl/smul_top.sv
module smul_top import smul_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PROD_W-1:0] data_i,
    input  logic [COEF_W-1:0] coef_i,
    output logic              done_o,
    output logic [PROD_W-1:0] prod_o
);
    state_e                  state_q;
    smag_t                   data_q;
    term_t [TERMS-1:0]       terms_q;
    term_t [TERMS-1:0]       coef_in;
    logic  [TERMS-1:0]       vmask;
    logic  [TERMS-1:0]       pend_q;
    logic                    any;
    logic  [IDX_W-1:0]       idx;
    logic  [TERMS-1:0]       onehot;
    term_t                   sel;
    logic  [MAG_W-1:0]       part;
    logic                    lost;
    logic signed [ACC_W-1:0] acc;
    logic                    sticky;
    logic  [PROD_W-1:0]      prod_next;
    logic                    accept;
    logic                    step;

    assign coef_in = coef_i;

    for (genvar j = 0; j < TERMS; j++) begin : g_valid
        assign vmask[j] = coef_in[j].valid;
    end

    assign accept = (state_q == ST_IDLE) && start_i;
    assign step   = (state_q == ST_RUN) && any;
    assign sel    = terms_q[idx];

    smul_pick u_pick (
        .pend   (pend_q),
        .any    (any),
        .idx    (idx),
        .onehot (onehot)
    );

    smul_shift u_shift (
        .mag   (data_q.mag),
        .shamt (sel.shamt),
        .part  (part),
        .lost  (lost)
    );

    smul_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .en       (step),
        .sub      (sel.sub),
        .part     (part),
        .lost     (lost),
        .acc_q    (acc),
        .sticky_q (sticky)
    );

    smul_final u_final (
        .acc    (acc),
        .sticky (sticky),
        .dneg   (data_q.neg),
        .prod   (prod_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            terms_q <= '0;
            pend_q  <= '0;
            done_o  <= 1'b0;
            prod_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        data_q  <= data_i;
                        terms_q <= coef_in;
                        pend_q  <= vmask;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (any) begin
                        pend_q <= pend_q & ~onehot;
                    end else begin
                        done_o  <= 1'b1;
                        prod_o  <= prod_next;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smul_chk.sv
module smul_chk import smul_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic [PROD_W-1:0] prod_o,
    input logic              run,
    input logic [TERMS-1:0]  pend,
    input logic [PROD_W-1:0] data_q
);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_drained_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!run && pend == '0));

    assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (run && start_i) |=> $stable(data_q));

    assert_no_neg_limit_R6: assert property (@(posedge clk) disable iff (rst)
        prod_o != {1'b1, {(PROD_W-1){1'b0}}});

    assert_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && data_q[MAG_W-1:0] == '0) |-> prod_o == '0);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(prod_o));
endmodule

bind smul_top smul_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .prod_o  (prod_o),
    .run     (state_q == ST_RUN),
    .pend    (pend_q),
    .data_q  (data_q)
);

// File: tb/smul_top_test.sv
module smul_top_test;
    import smul_pkg::*;

    localparam int CLK_NS = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [PROD_W-1:0] data_i = '0;
    logic [COEF_W-1:0] coef_i = '0;
    logic              done_o;
    logic [PROD_W-1:0] prod_o;

    int    total = 0;
    int    fails = 0;
    string tag = "R1";

    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic [15:0] m_prod = '0;
    logic [15:0] m_res = '0;

    smul_top uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .data_i  (data_i),
        .coef_i  (coef_i),
        .done_o  (done_o),
        .prod_o  (prod_o)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic logic [5:0] tm(input bit v, input bit sub, input int s);
        return {v, sub, 4'(s)};
    endfunction

    function automatic int nvalid(input logic [17:0] c);
        int n = 0;
        for (int j = 0; j < 3; j++) if (c[j*6+5]) n++;
        return n;
    endfunction

    function automatic logic [15:0] ref_prod(input logic [15:0] d, input logic [17:0] c);
        int mag = int'(d[14:0]);
        int acc = 0;
        bit st = 0;
        int m;
        int r;
        for (int j = 0; j < 3; j++) begin
            logic [5:0] t = c[j*6 +: 6];
            if (t[5]) begin
                int s = int'(t[3:0]);
                int p = mag >> s;
                if ((mag % (1 << s)) != 0) st = 1;
                acc = t[4] ? acc - p : acc + p;
                if (acc > 32767) acc = 32767;
                if (acc < -32767) acc = -32767;
            end
        end
        m = (acc < 0) ? -acc : acc;
        if (st && m != 0) m++;
        if (m > 32767) m = 32767;
        if (m == 0) return 16'h0;
        r = ((d[15] ^ (acc < 0)) != 0) ? -m : m;
        return 16'(r);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_done = 1'b0;
            m_prod = '0;
        end else if (m_cnt == 0) begin
            m_done = 1'b0;
            if (start_i) begin
                m_res = ref_prod(data_i, coef_i);
                m_cnt = nvalid(coef_i) + 1;
            end
        end else begin
            m_cnt--;
            m_done = (m_cnt == 0);
            if (m_done) m_prod = m_res;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst) begin
            check("R1", {15'b0, done_o}, 16'h0);
            check("R1", prod_o, 16'h0);
        end else begin
            check("R2", {15'b0, done_o}, {15'b0, m_done});
            check(m_done ? tag : "R9", prod_o, m_prod);
        end
    end

    task automatic op(input logic [15:0] d, input logic [17:0] c, input string t);
        @(negedge clk);
        tag = t;
        data_i = d;
        coef_i = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 100000);
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: identity term and plain shifts
        op(16'd1234, {tm(0,0,0), tm(0,0,0), tm(1,0,0)}, "R4");
        op(16'd4096, {tm(1,0,3), tm(1,1,4), tm(1,0,1)}, "R4");
        // R7: negative data and negative coefficient
        op(16'h8000 | 16'd1000, {tm(0,0,0), tm(0,0,0), tm(1,0,0)}, "R7");
        op(16'h8000 | 16'd1000, {tm(0,0,0), tm(0,0,0), tm(1,1,2)}, "R7");
        op(16'd777, {tm(0,0,0), tm(1,0,5), tm(1,1,0)}, "R7");
        // R5: truncation with correction, exact without
        op(16'd1001, {tm(0,0,0), tm(1,1,3), tm(1,0,1)}, "R5");
        op(16'd1024, {tm(0,0,0), tm(1,0,2), tm(1,0,1)}, "R5");
        op(16'd3, {tm(0,0,0), tm(1,1,1), tm(1,0,1)}, "R5");
        op(16'd1, {tm(0,0,0), tm(0,0,0), tm(1,0,15)}, "R5");
        // R6: saturation, order dependent
        op(16'd32767, {tm(1,0,0), tm(1,0,0), tm(1,0,0)}, "R6");
        op(16'h8000 | 16'd32767, {tm(1,0,0), tm(1,0,0), tm(1,0,0)}, "R6");
        op(16'd32767, {tm(1,0,0), tm(1,1,0), tm(1,1,0)}, "R6");
        op(16'd32767, {tm(0,0,0), tm(1,0,1), tm(1,0,0)}, "R6");
        // R8: zero results
        op(16'h8000, {tm(1,0,0), tm(1,0,2), tm(1,1,1)}, "R8");
        op(16'h8000 | 16'd500, {tm(0,1,1), tm(0,0,2), tm(0,1,0)}, "R8");
        // R2: invalid middle term costs no cycle
        op(16'd2000, {tm(1,0,2), tm(0,1,0), tm(1,0,0)}, "R2");
        op(16'd2000, {tm(1,0,0), tm(0,0,0), tm(0,0,0)}, "R2");
        // R3: start while busy is ignored
        @(negedge clk);
        tag = "R3";
        data_i = 16'd900;
        coef_i = {tm(1,0,1), tm(1,0,2), tm(1,0,3)};
        start_i = 1'b1;
        @(negedge clk);
        data_i = 16'h8000 | 16'd5;
        coef_i = {tm(0,0,0), tm(0,0,0), tm(1,1,0)};
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        // R4: random operands
        for (int n = 0; n < 300; n++) begin
            logic [15:0] d = 16'($urandom);
            logic [17:0] c = 18'($urandom);
            op(d, c, "R4");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule